// File: doc/BRIEF.md
# Regulator Power-Good Monitor with Event Interrupt

This block decides whether a regulator output is inside its valid range, using two comparator results that arrive from the analog side without a clock: one says the output is above the lower threshold, the other says it is above the upper threshold. Both pass through a synchronizer and then a stability filter. A change of validity is accepted only after the new value has held for a set number of cycles, so short glitches have no effect. A mode input picks the rule. In lower-threshold-only mode, valid means above the lower threshold. In window mode, valid means above the lower threshold and not above the upper one.

The accepted validity drives a live status output, where 1 means valid. Every accepted change of validity is an event: a change to valid is a rise and a change to invalid is a fall. Each kind of event has its own mask. An unmasked event sets a sticky flag, which stays set until software writes 1 to clear it. The interrupt output follows the flag. While the converter is disabled, the status reads 0, the filter starts over, and no events are produced.

Top module: `pg_window_monitor`

## Requirements
- R1: When `window_mode` is 0, validity equals the synchronized `uv_ok_async`, and `ov_trip_async` has no effect on the status or on the flag.
- R2: When `window_mode` is 1, validity is `uv_ok_async` AND NOT `ov_trip_async`.
- R3: `pg_status` shows the accepted validity (1 valid, 0 invalid). With `conv_en` high, a change of validity that then holds appears on `pg_status` at the rising edge numbered SYNC_STAGES+FILTER_CYCLES, counting the first edge that samples the new input as edge 1.
- R4: A change of validity that lasts fewer than FILTER_CYCLES sampled cycles leaves `pg_status` and `pg_flag` unchanged.
- R5: An accepted change from invalid to valid sets `pg_flag` at the same edge that raises `pg_status`, unless `mask_rise` is 1.
- R6: An accepted change from valid to invalid sets `pg_flag` at the same edge that lowers `pg_status`, unless `mask_fall` is 1.
- R7: In window mode, crossing above the upper threshold is a fall event and returning below it is a rise event, and these use the same masks as crossings of the lower threshold.
- R8: `pg_flag` is sticky. A cycle with `flag_clr` at 1 clears it at the next edge. If an unmasked event occurs in the same cycle as the clear, the flag stays set.
- R9: `irq` is 1 exactly when `pg_flag` is 1.
- R10: While `conv_en` is 0, `pg_status` reads 0 in the same cycle, no event sets the flag, and the filter restarts. After re-enable, a valid input needs a full FILTER_CYCLES to be accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_en | input | 1 | Converter enabled; 0 forces the status low and suppresses events |
| uv_ok_async | input | 1 | Comparator: output above the lower threshold (unsynchronized) |
| ov_trip_async | input | 1 | Comparator: output above the upper threshold (unsynchronized) |
| window_mode | input | 1 | 0 selects lower-threshold-only checking, 1 selects window checking |
| mask_rise | input | 1 | 1 stops a change to valid from setting the flag |
| mask_fall | input | 1 | 1 stops a change to invalid from setting the flag |
| flag_clr | input | 1 | Write-1-to-clear strobe for the flag |
| pg_status | output | 1 | Live validity, 1 means valid |
| pg_flag | output | 1 | Sticky power-good event flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with SYNC_STAGES=2 and FILTER_CYCLES=3. These values keep the input-to-status latency at five edges. With that short filter, a two-cycle glitch counts as too short, while a three-cycle hold is accepted, so both sides of the acceptance boundary are tested. The short latency also leaves room to place a rise or fall event in the same cycle as a clear strobe, and to drop and raise `conv_en` while the filter is counting partway through.

// File: rtl/pg_pkg.sv
package pg_pkg;

  // Validity rule: lower threshold only, or full window.
  function automatic logic pg_valid(input logic uv_ok, input logic ov_trip,
                                    input logic win);
    return uv_ok & (~win | ~ov_trip);
  endfunction

  // Counter width for a stability count.
  function automatic int unsigned cnt_width(input int unsigned cycles);
    return (cycles < 2) ? 1 : $clog2(cycles);
  endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else if (STAGES == 1) chain_q <= d_async[b];
      else chain_q <= {chain_q[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/pg_filter.sv
module pg_filter #(
  parameter int unsigned FILTER_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cand,
  output logic valid_q,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int unsigned CNT_W = pg_pkg::cnt_width(FILTER_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILTER_CYCLES - 1);

  logic [CNT_W-1:0] run_q;
  logic             differs;
  logic             commit;

  assign differs  = enable & (cand != valid_q);
  assign commit   = differs & (run_q == LAST);
  assign rise_evt = commit & cand;
  assign fall_evt = commit & ~cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      run_q   <= '0;
    end else if (!enable) begin
      valid_q <= 1'b0;
      run_q   <= '0;
    end else if (!differs) begin
      run_q <= '0;
    end else if (commit) begin
      valid_q <= cand;
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/pg_flag_reg.sv
module pg_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_evt,
  input  logic fall_evt,
  input  logic mask_rise,
  input  logic mask_fall,
  input  logic clr,
  output logic flag_q
);
  logic set_evt;
  assign set_evt = (rise_evt & ~mask_rise) | (fall_evt & ~mask_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end
endmodule

// File: rtl/pg_window_monitor.sv
module pg_window_monitor #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned FILTER_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_en,
  input  logic uv_ok_async,
  input  logic ov_trip_async,
  input  logic window_mode,
  input  logic mask_rise,
  input  logic mask_fall,
  input  logic flag_clr,
  output logic pg_status,
  output logic pg_flag,
  output logic irq
);
  logic [1:0] cmp_sync;
  logic       cand_valid;
  logic       valid_q;
  logic       rise_evt;
  logic       fall_evt;

  pg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({ov_trip_async, uv_ok_async}),
    .q_sync(cmp_sync)
  );

  assign cand_valid = pg_pkg::pg_valid(cmp_sync[0], cmp_sync[1], window_mode);

  pg_filter #(.FILTER_CYCLES(FILTER_CYCLES)) u_filter (
    .clk(clk), .rst_n(rst_n), .enable(conv_en), .cand(cand_valid),
    .valid_q(valid_q), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  pg_flag_reg u_flag (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .mask_rise(mask_rise), .mask_fall(mask_fall), .clr(flag_clr),
    .flag_q(pg_flag)
  );

  assign pg_status = valid_q & conv_en;
  assign irq       = pg_flag;
endmodule

// File: rtl/pg_window_monitor_chk.sv
module pg_window_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_en,
  input logic mask_rise,
  input logic mask_fall,
  input logic flag_clr,
  input logic rise_evt,
  input logic fall_evt,
  input logic pg_status,
  input logic pg_flag
);
  // R3
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_evt, fall_evt}));

  // R3
  status_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_status) |-> $past(rise_evt));

  // R5
  rise_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !mask_rise) |=> pg_flag);

  // R6
  fall_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && !mask_fall) |=> pg_flag);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_flag && !flag_clr) |=> pg_flag);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !rise_evt && !fall_evt) |=> !pg_flag);

  // R10
  off_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_en && !pg_flag) |=> !pg_flag);
endmodule

bind pg_window_monitor pg_window_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .conv_en(conv_en),
  .mask_rise(mask_rise), .mask_fall(mask_fall), .flag_clr(flag_clr),
  .rise_evt(rise_evt), .fall_evt(fall_evt),
  .pg_status(pg_status), .pg_flag(pg_flag)
);

// File: tb/pg_window_monitor_tb_top.sv
module pg_window_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC_N = 2;
  localparam int FILT_N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_en = 1'b0, uv_in = 1'b0, ov_in = 1'b0, win = 1'b0;
  logic m_rise = 1'b0, m_fall = 1'b0, clr = 1'b0;
  logic pg_status, pg_flag, irq;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int uv_hist[$];
  int ov_hist[$];
  int ref_valid = 0;
  int ref_run = 0;
  int ref_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pg_window_monitor #(.SYNC_STAGES(SYNC_N), .FILTER_CYCLES(FILT_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .uv_ok_async(uv_in),
    .ov_trip_async(ov_in), .window_mode(win), .mask_rise(m_rise),
    .mask_fall(m_fall), .flag_clr(clr), .pg_status(pg_status),
    .pg_flag(pg_flag), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    uv_hist.delete(); ov_hist.delete();
    for (int i = 0; i < SYNC_N; i++) begin
      uv_hist.push_back(0); ov_hist.push_back(0);
    end
    ref_valid = 0; ref_run = 0; ref_flag = 0;
  endtask

  task automatic model_edge();
    int want;
    int fired_rise;
    int fired_fall;
    fired_rise = 0; fired_fall = 0;
    if (win) want = (uv_hist[0] == 1 && ov_hist[0] == 0) ? 1 : 0;
    else     want = uv_hist[0];
    if (!conv_en) begin
      ref_valid = 0; ref_run = 0;
    end else if (want == ref_valid) begin
      ref_run = 0;
    end else begin
      ref_run++;
      if (ref_run == FILT_N) begin
        ref_valid = want; ref_run = 0;
        if (want == 1) fired_rise = 1; else fired_fall = 1;
      end
    end
    if ((fired_rise == 1 && !m_rise) || (fired_fall == 1 && !m_fall)) ref_flag = 1;
    else if (clr) ref_flag = 0;
    void'(uv_hist.pop_front()); void'(ov_hist.pop_front());
    uv_hist.push_back(int'(uv_in)); ov_hist.push_back(int'(ov_in));
  endtask

  task automatic compare_all();
    check("R3 status vs model", int'(pg_status), conv_en ? ref_valid : 0);
    check("R8 flag vs model", int'(pg_flag), ref_flag);
    check("R9 irq vs model", int'(irq), ref_flag);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      #1;
      compare_all();
    end
  endtask

  task automatic clear_flag();
    clr = 1'b1; step(1); clr = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R3 reset status", int'(pg_status), 0);
    check("R9 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    conv_en = 1'b1;
    step(2);

    // R3 latency and R5 rise event
    uv_in = 1'b1;
    step(SYNC_N + FILT_N - 1);
    check("R3 status before latency", int'(pg_status), 0);
    step(1);
    check("R3 status at latency", int'(pg_status), 1);
    check("R5 rise sets flag", int'(pg_flag), 1);
    check("R9 irq follows flag", int'(irq), 1);

    // R8 clear
    clear_flag();
    check("R8 cleared", int'(pg_flag), 0);
    step(3);
    check("R8 stays clear", int'(pg_flag), 0);

    // R4 short glitch
    uv_in = 1'b0; step(FILT_N - 1); uv_in = 1'b1;
    step(SYNC_N + FILT_N + 2);
    check("R4 glitch status", int'(pg_status), 1);
    check("R4 glitch flag", int'(pg_flag), 0);

    // R1 over-threshold ignored in lower-only mode
    ov_in = 1'b1;
    step(SYNC_N + FILT_N + 3);
    check("R1 ov ignored status", int'(pg_status), 1);
    check("R1 ov ignored flag", int'(pg_flag), 0);

    // R2/R7 window mode: over-threshold is a fall
    win = 1'b1;
    step(SYNC_N + FILT_N);
    check("R2 window invalid", int'(pg_status), 0);
    check("R7 upper fall flag", int'(pg_flag), 1);
    clear_flag();

    // R7 upper recovery is a rise; masked
    m_rise = 1'b1; ov_in = 1'b0;
    step(SYNC_N + FILT_N + 1);
    check("R7 upper recovery valid", int'(pg_status), 1);
    check("R5 masked rise", int'(pg_flag), 0);

    // R6 masked fall
    m_fall = 1'b1; uv_in = 1'b0;
    step(SYNC_N + FILT_N + 1);
    check("R6 masked fall status", int'(pg_status), 0);
    check("R6 masked fall flag", int'(pg_flag), 0);

    // R6 unmasked fall
    m_rise = 1'b0; m_fall = 1'b0; uv_in = 1'b1;
    step(SYNC_N + FILT_N + 1);
    clear_flag();
    uv_in = 1'b0;
    step(SYNC_N + FILT_N + 1);
    check("R6 fall sets flag", int'(pg_flag), 1);

    // R8 set wins over same-cycle clear
    clear_flag();
    clr = 1'b1; uv_in = 1'b1;
    step(SYNC_N + FILT_N);
    check("R8 set beats clear", int'(pg_flag), 1);
    step(1);
    clr = 1'b0;
    check("R8 clear after event", int'(pg_flag), 0);

    // R10 disable: status drops immediately, no fall event
    conv_en = 1'b0;
    #1;
    check("R10 status off", int'(pg_status), 0);
    step(SYNC_N + FILT_N + 2);
    check("R10 no event while off", int'(pg_flag), 0);
    conv_en = 1'b1;
    step(FILT_N - 1);
    check("R10 refilter pending", int'(pg_status), 0);
    step(1);
    check("R10 refilter done", int'(pg_status), 1);
    check("R10 rise after enable", int'(pg_flag), 1);

    // R10 brief disable during counting restarts filter
    clear_flag();
    uv_in = 1'b0; step(SYNC_N + 1);
    conv_en = 1'b0; step(1); conv_en = 1'b1;
    step(FILT_N + 2);
    check("R10 short off pulse flag", int'(pg_flag), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule